// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

This block is the issue stage of a small out-of-order core. It holds a fixed number of entries, and each entry records a sequence number and an instruction class. Dispatch writes one instruction per cycle into the lowest-indexed free entry. The block reports the index it will use, how many entries are free, and a full flag. Operand wakeup is outside the block: it arrives as one ready input per entry, and whoever wakes operands uses the reported index to find the entry.

Every cycle the block picks instructions for execute from the entries whose ready input is high. The greedy pick takes the oldest instruction first, using a wrap-aware comparison of sequence numbers. A pick is skipped when its class has already reached its own per-cycle cap. The total number of picks is capped by the issue width. Each picked entry leaves the queue at the next clock edge. An instruction marked non-speculative is held back until commit names its sequence number. A squash removes every entry younger than a given sequence number.

Each entry is a small state machine with four states. `ST_FREE` is an empty entry. `ST_SPEC` is a normal instruction waiting to issue. `ST_HOLD` is a non-speculative instruction waiting for release. `ST_GO` is a released non-speculative instruction. The transitions are:
- dispatch: `ST_FREE` to `ST_SPEC`, or `ST_FREE` to `ST_HOLD` when the instruction is non-speculative;
- release: `ST_HOLD` to `ST_GO`;
- issue: `ST_SPEC` to `ST_FREE` and `ST_GO` to `ST_FREE`;
- squash: `ST_SPEC`, `ST_HOLD` or `ST_GO` to `ST_FREE`.

Top module: `age_issue_sel`

## Requirements
- R1: After reset every entry is free: `free_cnt` equals DEPTH (8), `full` is 0 and no issue slot is valid.
- R2: An accepted dispatch fills the lowest-indexed free entry, whose index is shown on `alloc_idx`; `free_cnt` drops by one after the next clock edge.
- R3: `full` is 1 exactly when no entry is free; a dispatch while full is refused and changes nothing.
- R4: An entry can be picked only while its `entry_ready` bit is high, and no earlier than the cycle after its dispatch.
- R5: Age is the wrap-aware 16-bit difference of sequence numbers (a is older than b when bit 15 of a-b is set). Among the candidates, the oldest is picked first, and on equal sequence numbers the lower entry index wins.
- R6: Within one cycle, no class issues more than its cap. The default caps are integer 2, float 1, branch 1, memory 1 and miscellaneous 1.
- R7: At most ISSUE_W (3) instructions issue per cycle. Valid slots are packed from slot 0 upward in order of age.
- R8: A picked entry is freed at the clock edge that ends its issue cycle.
- R9: A non-speculative entry does not issue until a release carrying its sequence number has been presented. With REL_DELAY=1, the entry can issue from the second cycle after the release cycle.
- R10: A squash frees every entry whose sequence number is younger than `squash_seq` and keeps the others. In the squash cycle nothing issues and dispatch is refused.
- R11: Class codes are integer 0, float 1, branch 2, memory 3 and miscellaneous 4, and `iss_cls` carries the issued entry's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_cls | input | 3 | Class code of the dispatched instruction |
| disp_seq | input | SEQ_W | Sequence number of the dispatched instruction |
| disp_nonspec | input | 1 | Instruction waits for a commit release |
| alloc_idx | output | IDX_W | Entry that the next accepted dispatch fills |
| free_cnt | output | CNT_W | Number of free entries |
| full | output | 1 | No free entry |
| entry_ready | input | DEPTH | Operands ready, one bit per entry |
| rel_valid | input | 1 | Commit release request |
| rel_seq | input | SEQ_W | Sequence number being released |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Youngest sequence number that survives |
| iss_valid | output | ISSUE_W | Issue slot valid flags |
| iss_cls | output | ISSUE_W x 3 | Class code per issue slot |
| iss_seq | output | ISSUE_W x SEQ_W | Sequence number per issue slot |

## Verification
Some properties can be checked on every cycle. The assertions cover these: the packing and age order of the issue slots, the class caps, silence during a squash, that a held entry is never picked, that every pick has its ready bit, and how `free_cnt` behaves while the queue is full or squashing. Other behaviour needs a prepared queue state, and only the bench scenarios can show it: which entry dispatch chooses, the tie-break toward the lower index, age order across the wrap of the sequence numbers, the exact cycle at which a released instruction first issues, and which entries a squash keeps.

// File: rtl/ais_pkg.sv
package ais_pkg;
    localparam int CLS_W   = 3;
    localparam int NUM_CLS = 5;

    typedef enum logic [CLS_W-1:0] {
        CL_INT  = 3'd0,
        CL_FP   = 3'd1,
        CL_BR   = 3'd2,
        CL_MEM  = 3'd3,
        CL_MISC = 3'd4
    } cls_e;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_SPEC = 2'd1,
        ST_HOLD = 2'd2,
        ST_GO   = 2'd3
    } ent_st_e;

    // Codes above the last class share the miscellaneous cap.
    function automatic int cls_slot(input logic [CLS_W-1:0] c);
        return (c > CL_MISC) ? int'(CL_MISC) : int'(c);
    endfunction
endpackage

// File: rtl/ais_release_pipe.sv
module ais_release_pipe #(
    parameter int SEQ_W = 16,
    parameter int DELAY = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_v,
    input  logic [SEQ_W-1:0] in_seq,
    output logic             out_v,
    output logic [SEQ_W-1:0] out_seq
);
    // DELAY must be at least 1: each stage is one register.
    logic [DELAY-1:0]            v_q;
    logic [DELAY-1:0][SEQ_W-1:0] s_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
            s_q <= '0;
        end else begin
            v_q[0] <= in_v;
            s_q[0] <= in_seq;
            for (int k = 1; k < DELAY; k++) begin
                v_q[k] <= v_q[k-1];
                s_q[k] <= s_q[k-1];
            end
        end
    end

    assign out_v   = v_q[DELAY-1];
    assign out_seq = s_q[DELAY-1];
endmodule

// File: rtl/ais_free_find.sv
module ais_free_find #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic [DEPTH-1:0] free_vec,
    output logic [IDX_W-1:0] first_idx,
    output logic [CNT_W-1:0] free_cnt,
    output logic             none_free
);
    always_comb begin
        first_idx = '0;
        free_cnt  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_vec[i]) first_idx = IDX_W'(i);
        end
        for (int i = 0; i < DEPTH; i++) begin
            free_cnt = free_cnt + CNT_W'(free_vec[i]);
        end
        none_free = (free_vec == '0);
    end
endmodule

// File: rtl/ais_picker.sv
module ais_picker
    import ais_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int IDX_W    = 3,
    parameter int SEQ_W    = 16,
    parameter int ISSUE_W  = 3,
    parameter int CAP_INT  = 2,
    parameter int CAP_FP   = 1,
    parameter int CAP_BR   = 1,
    parameter int CAP_MEM  = 1,
    parameter int CAP_MISC = 1
) (
    input  logic [DEPTH-1:0]              elig,
    input  logic [DEPTH-1:0][SEQ_W-1:0]   seq,
    input  logic [DEPTH-1:0][CLS_W-1:0]   cls,
    output logic [ISSUE_W-1:0]            pick_v,
    output logic [ISSUE_W-1:0][IDX_W-1:0] pick_idx,
    output logic [DEPTH-1:0]              taken
);
    localparam int CAP [NUM_CLS] = '{CAP_INT, CAP_FP, CAP_BR, CAP_MEM, CAP_MISC};

    function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return d[SEQ_W-1];
    endfunction

    int               used [NUM_CLS];
    logic             found;
    logic [IDX_W-1:0] best;

    // Greedy slot fill: each slot takes the oldest entry not yet taken
    // whose class still has room under its cap.
    always_comb begin
        taken    = '0;
        pick_v   = '0;
        pick_idx = '0;
        found    = 1'b0;
        best     = '0;
        for (int c = 0; c < NUM_CLS; c++) used[c] = 0;
        for (int s = 0; s < ISSUE_W; s++) begin
            found = 1'b0;
            best  = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (elig[i] && !taken[i] && (used[cls_slot(cls[i])] < CAP[cls_slot(cls[i])])) begin
                    if (!found || older(seq[i], seq[best])) begin
                        found = 1'b1;
                        best  = IDX_W'(i);
                    end
                end
            end
            if (found) begin
                pick_v[s]   = 1'b1;
                pick_idx[s] = best;
                taken[best] = 1'b1;
                used[cls_slot(cls[best])] = used[cls_slot(cls[best])] + 1;
            end
        end
    end
endmodule

// File: rtl/age_issue_sel.sv
module age_issue_sel
    import ais_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int SEQ_W     = 16,
    parameter int ISSUE_W   = 3,
    parameter int CAP_INT   = 2,
    parameter int CAP_FP    = 1,
    parameter int CAP_BR    = 1,
    parameter int CAP_MEM   = 1,
    parameter int CAP_MISC  = 1,
    parameter int REL_DELAY = 1,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            disp_valid,
    input  logic [CLS_W-1:0]                disp_cls,
    input  logic [SEQ_W-1:0]                disp_seq,
    input  logic                            disp_nonspec,
    output logic [IDX_W-1:0]                alloc_idx,
    output logic [CNT_W-1:0]                free_cnt,
    output logic                            full,
    input  logic [DEPTH-1:0]                entry_ready,
    input  logic                            rel_valid,
    input  logic [SEQ_W-1:0]                rel_seq,
    input  logic                            squash_valid,
    input  logic [SEQ_W-1:0]                squash_seq,
    output logic [ISSUE_W-1:0]              iss_valid,
    output logic [ISSUE_W-1:0][CLS_W-1:0]   iss_cls,
    output logic [ISSUE_W-1:0][SEQ_W-1:0]   iss_seq
);
    localparam int CAP [NUM_CLS] = '{CAP_INT, CAP_FP, CAP_BR, CAP_MEM, CAP_MISC};

    function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return d[SEQ_W-1];
    endfunction

    ent_st_e                     st_q [DEPTH];
    ent_st_e                     st_d [DEPTH];
    logic [DEPTH-1:0][SEQ_W-1:0] seq_q;
    logic [DEPTH-1:0][CLS_W-1:0] cls_q;
    logic [DEPTH-1:0]            free_vec, elig, kill, issued, rel_hit, load;
    logic                        rel_v, disp_go;
    logic [SEQ_W-1:0]            rel_s;
    logic [ISSUE_W-1:0][IDX_W-1:0] pick_idx;

    ais_release_pipe #(.SEQ_W(SEQ_W), .DELAY(REL_DELAY)) u_rel (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_v    (rel_valid),
        .in_seq  (rel_seq),
        .out_v   (rel_v),
        .out_seq (rel_s)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            free_vec[i] = (st_q[i] == ST_FREE);
            elig[i]     = ((st_q[i] == ST_SPEC) || (st_q[i] == ST_GO)) && entry_ready[i] && !squash_valid;
            kill[i]     = squash_valid && older(squash_seq, seq_q[i]);
            rel_hit[i]  = rel_v && (rel_s == seq_q[i]);
        end
    end

    ais_free_find #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_free (
        .free_vec  (free_vec),
        .first_idx (alloc_idx),
        .free_cnt  (free_cnt),
        .none_free (full)
    );

    assign disp_go = disp_valid && !full && !squash_valid;

    ais_picker #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .SEQ_W(SEQ_W), .ISSUE_W(ISSUE_W),
        .CAP_INT(CAP_INT), .CAP_FP(CAP_FP), .CAP_BR(CAP_BR),
        .CAP_MEM(CAP_MEM), .CAP_MISC(CAP_MISC)
    ) u_pick (
        .elig     (elig),
        .seq      (seq_q),
        .cls      (cls_q),
        .pick_v   (iss_valid),
        .pick_idx (pick_idx),
        .taken    (issued)
    );

    // Per-entry next state
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            load[i] = disp_go && free_vec[i] && (alloc_idx == IDX_W'(i));
            st_d[i] = st_q[i];
            unique case (st_q[i])
                ST_FREE: if (load[i]) st_d[i] = disp_nonspec ? ST_HOLD : ST_SPEC;
                ST_SPEC,
                ST_GO:   if (kill[i] || issued[i]) st_d[i] = ST_FREE;
                ST_HOLD: begin
                    if (kill[i])         st_d[i] = ST_FREE;
                    else if (rel_hit[i]) st_d[i] = ST_GO;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st_q[i] <= ST_FREE;
        end else begin
            for (int i = 0; i < DEPTH; i++) st_q[i] <= st_d[i];
        end
    end

    // Entry payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
            cls_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (load[i]) begin
                    seq_q[i] <= disp_seq;
                    cls_q[i] <= disp_cls;
                end
            end
        end
    end

    // Issue bus
    always_comb begin
        for (int s = 0; s < ISSUE_W; s++) begin
            iss_seq[s] = iss_valid[s] ? seq_q[pick_idx[s]] : '0;
            iss_cls[s] = iss_valid[s] ? cls_q[pick_idx[s]] : '0;
        end
    end

    AST_SQUASH_MUTES_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> (iss_valid == '0)) else $error("issue during squash"); // R10

    AST_SQUASH_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> (free_cnt >= $past(free_cnt))) else $error("squash took entries"); // R10

    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !squash_valid) |=> (free_cnt == CNT_W'($countones($past(issued))))) else $error("dispatch while full"); // R3

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent_chk
        AST_HOLD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[i] == ST_HOLD) |-> !issued[i]) else $error("held entry issued"); // R9
        AST_READY_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
            issued[i] |-> entry_ready[i]) else $error("entry issued without ready"); // R4
    end

    for (genvar s = 0; s + 1 < ISSUE_W; s++) begin : g_slot_chk
        AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
            !iss_valid[s] |-> !iss_valid[s+1]) else $error("slot gap"); // R7
        AST_SLOT_AGE: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[s+1] |-> !older(iss_seq[s+1], iss_seq[s])) else $error("slot age order"); // R5
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cap_chk
        logic [ISSUE_W-1:0] hit;
        always_comb begin
            for (int s = 0; s < ISSUE_W; s++) hit[s] = iss_valid[s] && (cls_slot(iss_cls[s]) == c);
        end
        AST_CLASS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hit) <= CAP[c]) else $error("class cap exceeded"); // R6
    end
endmodule

// File: tb/age_issue_sel_tb.sv
`timescale 1ns/1ps
module age_issue_sel_tb;
    localparam int DEPTH = 8, SEQ_W = 16, ISSUE_W = 3, IDX_W = 3, CNT_W = 4;
    localparam int CAPS [5] = '{2, 1, 1, 1, 1};

    logic clk = 1'b0, rst_n = 1'b0;
    logic disp_valid = 1'b0, disp_nonspec = 1'b0;
    logic [2:0] disp_cls = '0;
    logic [SEQ_W-1:0] disp_seq = '0, rel_seq = '0, squash_seq = '0;
    logic rel_valid = 1'b0, squash_valid = 1'b0;
    logic [DEPTH-1:0] entry_ready = '0;
    logic [IDX_W-1:0] alloc_idx;
    logic [CNT_W-1:0] free_cnt;
    logic full;
    logic [ISSUE_W-1:0] iss_valid;
    logic [ISSUE_W-1:0][2:0] iss_cls;
    logic [ISSUE_W-1:0][SEQ_W-1:0] iss_seq;

    always #2 clk = ~clk;

    age_issue_sel u_dut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_cls(disp_cls),
        .disp_seq(disp_seq), .disp_nonspec(disp_nonspec), .alloc_idx(alloc_idx),
        .free_cnt(free_cnt), .full(full), .entry_ready(entry_ready),
        .rel_valid(rel_valid), .rel_seq(rel_seq), .squash_valid(squash_valid),
        .squash_seq(squash_seq), .iss_valid(iss_valid), .iss_cls(iss_cls), .iss_seq(iss_seq)
    );

    int total = 0, bad = 0;
    // model: 0 free, 1 speculative, 2 held, 3 released
    int m_st [DEPTH];
    logic [15:0] m_seq [DEPTH];
    logic [2:0] m_cls [DEPTH];
    logic rq_v = 1'b0;
    logic [15:0] rq_s = '0;
    logic ev [ISSUE_W];
    int eidx [ISSUE_W];
    logic m_tk [DEPTH];
    logic [15:0] next_seq;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic m_older(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] d;
        d = a - b;
        return d[15];
    endfunction

    function automatic int m_free();
        int n = 0;
        for (int i = 0; i < DEPTH; i++) if (m_st[i] == 0) n++;
        return n;
    endfunction

    function automatic int m_first();
        for (int i = 0; i < DEPTH; i++) if (m_st[i] == 0) return i;
        return 0;
    endfunction

    function automatic int cslot(input logic [2:0] c);
        return (c > 3'd4) ? 4 : int'(c);
    endfunction

    task automatic m_pick();
        int used [5];
        for (int c = 0; c < 5; c++) used[c] = 0;
        for (int i = 0; i < DEPTH; i++) m_tk[i] = 1'b0;
        for (int s = 0; s < ISSUE_W; s++) begin
            int b = -1;
            for (int i = 0; i < DEPTH; i++) begin
                if ((m_st[i] == 1 || m_st[i] == 3) && entry_ready[i] && !squash_valid && !m_tk[i]
                    && used[cslot(m_cls[i])] < CAPS[cslot(m_cls[i])]) begin
                    if (b < 0) b = i;
                    else if (m_older(m_seq[i], m_seq[b])) b = i;
                end
            end
            ev[s] = (b >= 0);
            eidx[s] = (b >= 0) ? b : 0;
            if (b >= 0) begin
                m_tk[b] = 1'b1;
                used[cslot(m_cls[b])]++;
            end
        end
    endtask

    // Compare every output with the model, advance one clock, return inputs to idle.
    task automatic tick();
        int fc, fi;
        logic go;
        #0.4;
        fc = m_free();
        fi = m_first();
        chk("R2", "free_cnt", 32'(free_cnt), 32'(fc));
        chk("R3", "full", 32'(full), 32'(fc == 0));
        if (fc != 0) chk("R2", "alloc_idx", 32'(alloc_idx), 32'(fi));
        m_pick();
        for (int s = 0; s < ISSUE_W; s++) begin
            chk("R7", "iss_valid", 32'(iss_valid[s]), 32'(ev[s]));
            if (ev[s]) begin
                chk("R5", "iss_seq", 32'(iss_seq[s]), 32'(m_seq[eidx[s]]));
                chk("R11", "iss_cls", 32'(iss_cls[s]), 32'(m_cls[eidx[s]]));
            end
        end
        go = disp_valid && (fc != 0) && !squash_valid;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_st[i] != 0 && squash_valid && m_older(squash_seq, m_seq[i])) m_st[i] = 0;
            else if (m_tk[i]) m_st[i] = 0;
            else if (m_st[i] == 2 && rq_v && rq_s == m_seq[i]) m_st[i] = 3;
        end
        if (go) begin
            m_st[fi]  = disp_nonspec ? 2 : 1;
            m_seq[fi] = disp_seq;
            m_cls[fi] = disp_cls;
        end
        rq_v = rel_valid;
        rq_s = rel_seq;
        @(negedge clk);
        disp_valid = 1'b0;
        squash_valid = 1'b0;
        rel_valid = 1'b0;
        disp_nonspec = 1'b0;
    endtask

    task automatic disp_at(input logic [15:0] s, input logic [2:0] c, input logic ns);
        disp_valid = 1'b1;
        disp_seq = s;
        disp_cls = c;
        disp_nonspec = ns;
        tick();
    endtask

    task automatic disp(input logic [2:0] c, input logic ns);
        disp_at(next_seq, c, ns);
        next_seq++;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [15:0] s0, sn;
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) begin m_st[i] = 0; m_seq[i] = '0; m_cls[i] = '0; end
        next_seq = 16'h0040;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #0.4;
        chk("R1", "free_cnt", 32'(free_cnt), 32'd8);
        chk("R1", "full", 32'(full), 32'd0);
        chk("R1", "iss_valid", 32'(iss_valid), 32'd0);
        tick();

        // R2 / R4 / R8 single instruction
        s0 = next_seq;
        disp(3'd0, 1'b0);
        #0.4;
        chk("R2", "free_cnt after dispatch", 32'(free_cnt), 32'd7);
        chk("R4", "no issue without ready", 32'(iss_valid), 32'd0);
        tick();
        entry_ready = 8'h01;
        #0.4;
        chk("R4", "issue with ready", 32'(iss_valid), 32'd1);
        chk("R4", "issued seq", 32'(iss_seq[0]), 32'(s0));
        tick();
        #0.4;
        chk("R8", "entry freed", 32'(free_cnt), 32'd8);
        entry_ready = '0;
        tick();

        // R3 fill and refuse, then R6 integer cap while draining
        for (int k = 0; k < 8; k++) disp(3'd0, 1'b0);
        #0.4;
        chk("R3", "full set", 32'(full), 32'd1);
        disp_at(16'h7777, 3'd1, 1'b0);
        #0.4;
        chk("R3", "refused dispatch", 32'(free_cnt), 32'd0);
        entry_ready = '1;
        #0.4;
        chk("R6", "integer cap", 32'($countones(iss_valid)), 32'd2);
        repeat (4) tick();
        #0.4;
        chk("R8", "drained", 32'(free_cnt), 32'd8);

        // R7 total cap across classes
        entry_ready = '0;
        s0 = next_seq;
        disp(3'd0, 1'b0); disp(3'd0, 1'b0); disp(3'd1, 1'b0); disp(3'd2, 1'b0); disp(3'd3, 1'b0);
        entry_ready = '1;
        #0.4;
        chk("R7", "total cap", 32'($countones(iss_valid)), 32'd3);
        chk("R7", "slot0 oldest", 32'(iss_seq[0]), 32'(s0));
        chk("R6", "slot2 float", 32'(iss_cls[2]), 32'd1);
        tick(); tick();

        // R5 age across wrap
        entry_ready = '0;
        disp_at(16'h0001, 3'd1, 1'b0);
        disp_at(16'hFFFE, 3'd1, 1'b0);
        entry_ready = '1;
        #0.4;
        chk("R5", "wrap oldest", 32'(iss_seq[0]), 32'h0000FFFE);
        chk("R5", "float cap one", 32'(iss_valid), 32'd1);
        tick(); tick();

        // R5 tie goes to lower index
        entry_ready = '0;
        disp_at(16'h0100, 3'd1, 1'b0);
        disp_at(16'h0100, 3'd1, 1'b0);
        entry_ready = '1;
        tick();
        #0.4;
        chk("R5", "tie freed index", 32'(alloc_idx), 32'd0);
        tick();

        // R9 held until release, then issues two cycles later
        sn = next_seq;
        disp(3'd0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            #0.4;
            chk("R9", "held", 32'(iss_valid), 32'd0);
            tick();
        end
        rel_valid = 1'b1;
        rel_seq = sn;
        #0.4;
        chk("R9", "release cycle", 32'(iss_valid), 32'd0);
        tick();
        #0.4;
        chk("R9", "one cycle after release", 32'(iss_valid), 32'd0);
        tick();
        #0.4;
        chk("R9", "released issue", 32'(iss_valid), 32'd1);
        chk("R9", "released seq", 32'(iss_seq[0]), 32'(sn));
        tick();

        // R10 squash
        entry_ready = '0;
        next_seq = 16'h0010;
        for (int k = 0; k < 5; k++) disp(3'd0, 1'b0);
        entry_ready = '1;
        squash_valid = 1'b1;
        squash_seq = 16'h0012;
        disp_valid = 1'b1;
        disp_seq = 16'h0099;
        #0.4;
        chk("R10", "no issue on squash", 32'(iss_valid), 32'd0);
        tick();
        #0.4;
        chk("R10", "survivors", 32'(free_cnt), 32'd5);
        tick(); tick();
        next_seq = 16'h0013;

        // R11 class codes
        entry_ready = '0;
        disp(3'd4, 1'b0);
        disp(3'd2, 1'b0);
        entry_ready = '1;
        #0.4;
        chk("R11", "misc code", 32'(iss_cls[0]), 32'd4);
        chk("R11", "branch code", 32'(iss_cls[1]), 32'd2);
        tick();

        // random traffic with the wrap crossed
        next_seq = 16'hFFF0;
        for (int n = 0; n < 4000; n++) begin
            int k;
            logic acc;
            entry_ready = DEPTH'($urandom);
            if ($urandom % 5 == 0) entry_ready = '0;
            if ($urandom % 2 == 0) begin
                disp_valid = 1'b1;
                disp_cls = 3'($urandom % 5);
                disp_nonspec = ($urandom % 8 == 0);
                disp_seq = next_seq;
            end
            if ($urandom % 6 == 0) begin
                k = $urandom % DEPTH;
                if (m_st[k] == 2) begin rel_valid = 1'b1; rel_seq = m_seq[k]; end
            end
            if ($urandom % 50 == 0) begin
                k = $urandom % DEPTH;
                if (m_st[k] != 0) begin squash_valid = 1'b1; squash_seq = m_seq[k]; end
            end
            acc = disp_valid && (m_free() != 0) && !squash_valid;
            if (squash_valid) next_seq = squash_seq + 16'd1;
            else if (acc) next_seq++;
            tick();
        end
        summary();
    end
endmodule